// File: doc/BRIEF.md
# Maintenance Request Range Splitter

This block takes one cache maintenance request and turns it into a series of commands for a downstream range sequencer. A request names an operation (invalidate, clean or flush), a byte start address and an exclusive byte end address. Any byte address is allowed. The block emits two kinds of commands. A single-line clean-and-invalidate command covers a partial line at either edge of an invalidate. A range command has an inclusive, line-aligned first and last line. Commands leave one at a time over a valid/ready handshake.

Each range command is bounded. It stops at whichever comes first: the end of the request, a fixed byte cap measured from the chunk start, or the next 4096-byte page boundary. A flush is issued as a clean range followed by an invalidate range over the same span, chunk by chunk. A write-through mode input drops every clean-range command. When the last command of a request has been taken, a one-cycle completion pulse marks the point where a barrier may be placed. A new request is accepted only when the block is idle.

Top module: `maint_splitter`

## Requirements
- R1: `cmd_kind` encodes 0 = clean-and-invalidate of one line (`cmd_lo` = `cmd_hi` = line base), 1 = clean range, 2 = invalidate range. Every emitted address is a multiple of the line size (32 bytes by default). A range's `cmd_hi` is the inclusive last line, equal to the chunk's exclusive end minus one line.
- R2: A range chunk starting at `cmd_lo` ends at the smallest of three points: the aligned request end, `cmd_lo` plus the cap (1024 bytes by default), and the next 4096-byte page boundary. The next chunk starts where the previous one ended.
- R3: For an invalidate (`req_op` = 0) whose start is not line-aligned, the first command is a clean-and-invalidate of the line holding the start. The ranges then begin at the next line boundary.
- R4: For an invalidate whose end is not line-aligned, a clean-and-invalidate of the line holding the end follows the start-edge command. This happens only if the advanced start is still below the end. The ranges then stop at the end rounded down to a line.
- R5: For clean (`req_op` = 1) and flush (`req_op` = 2), the start is rounded down and the end rounded up to line boundaries before splitting.
- R6: A flush emits, for each chunk, a clean range and then an invalidate range with the same bounds.
- R7: While `wt_mode` is high at acceptance, no clean-range command is emitted. A clean request then produces only the completion pulse, and a flush produces only invalidate ranges.
- R8: `done` is high for exactly one cycle, the cycle after the handshake of the request's last command. If the request emits nothing, `done` is high the cycle after acceptance.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command stays valid and unchanged. Each handshake consumes exactly one command.
- R10: `req_ready` is high only while idle. It drops the cycle after a request is accepted, and request inputs presented while busy are not taken until the block is idle again.
- R11: `req_op` = 3 is a no-operation: no commands, only the completion pulse.
- R12: A request that is empty after alignment emits no commands, only the completion pulse.
- R13: During and right after reset, `req_ready` is 1 and `cmd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no-op |
| req_start | input | AW | First byte address |
| req_end | input | AW | Exclusive end byte address |
| wt_mode | input | 1 | Write-through mode: suppress clean ranges |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_kind | output | 2 | Command type (see R1) |
| cmd_lo | output | AW | First line address |
| cmd_hi | output | AW | Last line address (inclusive) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after these corner cases:
- An invalidate whose both edges fall in the same line. A design that ignores the R4 condition would emit a spurious second edge command there.
- An invalidate with both edges unaligned and a one-line interior.
- Requests that cross the cap.
- Requests that cross a page boundary. A design that caps wrongly would issue a range spanning two pages or longer than 1024 bytes.
- Flushes, which must interleave clean and invalidate ranges per chunk.
- Write-through requests, which must drop clean ranges.
- Empty requests and no-op requests, which must still produce a single completion pulse.

A randomized-looking ready pattern stalls the output, which exposes commands that change or are lost under back-pressure. A second request is also presented while the first is still busy, so early acceptance would interleave its completion into the first's stream.

// File: rtl/maint_pkg.sv
package maint_pkg;

  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_NONE  = 2'd3
  } maint_op_e;

  typedef enum logic [1:0] {
    K_CI_LINE     = 2'd0,
    K_CLEAN_RANGE = 2'd1,
    K_INV_RANGE   = 2'd2
  } cmd_kind_e;

endpackage

// File: rtl/maint_edge_align.sv
module maint_edge_align
  import maint_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [1:0]    op,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          head_need,
  output logic          tail_need,
  output logic [AW-1:0] head_line,
  output logic [AW-1:0] tail_line,
  output logic [AW-1:0] body_lo,
  output logic [AW-1:0] body_hi
);

  localparam logic [AW-1:0] LMASK = AW'(LINE_BYTES - 1);
  localparam logic [AW-1:0] LSTEP = AW'(LINE_BYTES);

  logic          s_unal, e_unal, is_inv;
  logic [AW-1:0] s_down, e_down, e_up, s_adv;

  always_comb begin
    is_inv = (maint_op_e'(op) == OP_INV);
    s_unal = (start_addr & LMASK) != '0;
    e_unal = (end_addr & LMASK) != '0;
    s_down = start_addr & ~LMASK;
    e_down = end_addr & ~LMASK;
    e_up   = e_unal ? (e_down + LSTEP) : e_down;
    s_adv  = s_unal ? (s_down + LSTEP) : start_addr;

    head_line = s_down;
    tail_line = e_down;

    if (is_inv) begin
      // edges of an invalidate become clean-and-invalidate single lines
      head_need = s_unal;
      tail_need = (s_adv < end_addr) && e_unal;
      body_lo   = s_adv;
      body_hi   = e_down;
    end else begin
      // clean and flush widen to whole lines
      head_need = 1'b0;
      tail_need = 1'b0;
      body_lo   = s_down;
      body_hi   = e_up;
    end
  end

endmodule

// File: rtl/maint_chunk_calc.sv
module maint_chunk_calc #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int CAP_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] lim,
  output logic [AW-1:0] chunk_end,
  output logic [AW-1:0] chunk_last
);

  localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);
  localparam logic [AW-1:0] CAP   = AW'(CAP_BYTES);
  localparam logic [AW-1:0] LSTEP = AW'(LINE_BYTES);

  logic [AW-1:0] cap_pt, page_pt, pick;

  always_comb begin
    cap_pt  = cur + CAP;
    page_pt = (cur | PMASK) + 1'b1;
    pick    = lim;
    if (cap_pt < pick)  pick = cap_pt;
    if (page_pt < pick) pick = page_pt;
    chunk_end  = pick;
    chunk_last = pick - LSTEP;
  end

endmodule

// File: rtl/maint_seq_ctrl.sv
module maint_seq_ctrl
  import maint_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int CAP_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          wt_mode,
  input  logic          head_need,
  input  logic          tail_need,
  input  logic [AW-1:0] head_line,
  input  logic [AW-1:0] tail_line,
  input  logic [AW-1:0] body_lo,
  input  logic [AW-1:0] body_hi,
  input  logic [AW-1:0] chunk_end,
  input  logic [AW-1:0] chunk_last,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] lim,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_lo,
  output logic [AW-1:0] cmd_hi,
  output logic          done
);

  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  // registers
  logic          busy_q, busy_d;
  maint_op_e     op_q, op_d;
  logic          wt_q, wt_d;
  logic          head_q, head_d;
  logic          tail_q, tail_d;
  logic          half_q, half_d;
  logic [AW-1:0] hline_q, hline_d;
  logic [AW-1:0] tline_q, tline_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] lim_q, lim_d;

  logic          body_left, work_left, accept, fire, skip_body;
  cmd_kind_e     kind;
  logic [AW-1:0] lo, hi;

  assign cur = cur_q;
  assign lim = lim_q;

  // command selection
  always_comb begin
    body_left = (cur_q < lim_q);
    work_left = head_q | tail_q | body_left;
    if (head_q) begin
      kind = K_CI_LINE;
      lo   = hline_q;
      hi   = hline_q;
    end else if (tail_q) begin
      kind = K_CI_LINE;
      lo   = tline_q;
      hi   = tline_q;
    end else begin
      if ((op_q == OP_CLEAN) || ((op_q == OP_FLUSH) && !wt_q && !half_q))
        kind = K_CLEAN_RANGE;
      else
        kind = K_INV_RANGE;
      lo = cur_q;
      hi = chunk_last;
    end
  end

  assign req_ready = ~busy_q;
  assign cmd_valid = busy_q & work_left;
  assign done      = busy_q & ~work_left;
  assign cmd_kind  = kind;
  assign cmd_lo    = lo;
  assign cmd_hi    = hi;
  assign accept    = req_valid & ~busy_q;
  assign fire      = cmd_valid & cmd_ready;

  // next state
  always_comb begin
    busy_d  = busy_q;
    op_d    = op_q;
    wt_d    = wt_q;
    head_d  = head_q;
    tail_d  = tail_q;
    half_d  = half_q;
    hline_d = hline_q;
    tline_d = tline_q;
    cur_d   = cur_q;
    lim_d   = lim_q;
    skip_body = (maint_op_e'(req_op) == OP_NONE) ||
                ((maint_op_e'(req_op) == OP_CLEAN) && wt_mode);

    if (accept) begin
      busy_d  = 1'b1;
      op_d    = maint_op_e'(req_op);
      wt_d    = wt_mode;
      head_d  = head_need & ~skip_body;
      tail_d  = tail_need & ~skip_body;
      half_d  = 1'b0;
      hline_d = head_line;
      tline_d = tail_line;
      cur_d   = body_lo;
      lim_d   = skip_body ? body_lo : body_hi;
    end else if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
      end else if (fire) begin
        if (head_q) begin
          head_d = 1'b0;
        end else if (tail_q) begin
          tail_d = 1'b0;
        end else if ((kind == K_CLEAN_RANGE) && (op_q == OP_FLUSH)) begin
          half_d = 1'b1;
        end else begin
          half_d = 1'b0;
          cur_d  = chunk_end;
        end
      end
    end
  end

  // register update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_q    <= OP_NONE;
      wt_q    <= 1'b0;
      head_q  <= 1'b0;
      tail_q  <= 1'b0;
      half_q  <= 1'b0;
      hline_q <= '0;
      tline_q <= '0;
      cur_q   <= '0;
      lim_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      op_q    <= op_d;
      wt_q    <= wt_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      half_q  <= half_d;
      hline_q <= hline_d;
      tline_q <= tline_d;
      cur_q   <= cur_d;
      lim_q   <= lim_d;
    end
  end

  // R9: stalled command holds
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) &&
                                   $stable(cmd_lo) && $stable(cmd_hi)));

  // R2: a range never crosses a page
  a_r2_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_lo[AW-1:PAGE_BITS] == cmd_hi[AW-1:PAGE_BITS]));

  // R2: a range never exceeds the cap
  a_r2_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_hi >= cmd_lo) && ((cmd_hi - cmd_lo) < AW'(CAP_BYTES))));

  // R1: line-aligned addresses
  a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_lo[LINE_BITS-1:0] == '0) && (cmd_hi[LINE_BITS-1:0] == '0)));

  // R10: no second acceptance right after one
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: write-through drops clean ranges
  a_r7_no_clean_wt: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wt_q) |-> (cmd_kind != 2'd1));

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: flush clean range is followed by the matching invalidate range
  a_r6_flush_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cmd_kind == 2'd1) && (op_q == OP_FLUSH)) |=>
      (cmd_valid && (cmd_kind == 2'd2) && (cmd_lo == $past(cmd_lo)) &&
       (cmd_hi == $past(cmd_hi))));

endmodule

// File: rtl/maint_splitter.sv
module maint_splitter
  import maint_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int CAP_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  input  logic          wt_mode,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_lo,
  output logic [AW-1:0] cmd_hi,
  output logic          done
);

  logic          head_need, tail_need;
  logic [AW-1:0] head_line, tail_line, body_lo, body_hi;
  logic [AW-1:0] cur, lim, chunk_end, chunk_last;

  maint_edge_align #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_align (
    .op         (req_op),
    .start_addr (req_start),
    .end_addr   (req_end),
    .head_need  (head_need),
    .tail_need  (tail_need),
    .head_line  (head_line),
    .tail_line  (tail_line),
    .body_lo    (body_lo),
    .body_hi    (body_hi)
  );

  maint_chunk_calc #(.AW(AW), .LINE_BYTES(LINE_BYTES), .CAP_BYTES(CAP_BYTES),
                     .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur        (cur),
    .lim        (lim),
    .chunk_end  (chunk_end),
    .chunk_last (chunk_last)
  );

  maint_seq_ctrl #(.AW(AW), .LINE_BYTES(LINE_BYTES), .CAP_BYTES(CAP_BYTES),
                   .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .wt_mode    (wt_mode),
    .head_need  (head_need),
    .tail_need  (tail_need),
    .head_line  (head_line),
    .tail_line  (tail_line),
    .body_lo    (body_lo),
    .body_hi    (body_hi),
    .chunk_end  (chunk_end),
    .chunk_last (chunk_last),
    .cur        (cur),
    .lim        (lim),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_kind   (cmd_kind),
    .cmd_lo     (cmd_lo),
    .cmd_hi     (cmd_hi),
    .done       (done)
  );

endmodule

// File: tb/maint_splitter_test.sv
module maint_splitter_test;

  localparam int AW = 32;

  logic          clk, rst_n;
  logic          req_valid, req_ready, wt_mode;
  logic [1:0]    req_op;
  logic [AW-1:0] req_start, req_end;
  logic          cmd_valid, cmd_ready, done;
  logic [1:0]    cmd_kind;
  logic [AW-1:0] cmd_lo, cmd_hi;

  maint_splitter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_start(req_start), .req_end(req_end), .wt_mode(wt_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int          kind;   // 0..2 command, 3 completion marker
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  logic stall_en = 1'b0;
  int   rdy_cnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] chunk_of(logic [31:0] s, logic [31:0] e);
    logic [31:0] r;
    r = e;
    if (r > s + 32'd1024) r = s + 32'd1024;
    if (r > ((s | 32'hFFF) + 32'd1)) r = (s | 32'hFFF) + 32'd1;
    return r;
  endfunction

  task automatic push(input int k, input logic [31:0] lo, input logic [31:0] hi,
                      input string tag);
    exp_t x;
    x.kind = k; x.lo = lo; x.hi = hi; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // expected stream from the requirements
  task automatic expect_req(input int op, input logic [31:0] s0,
                            input logic [31:0] e0, input bit wt, input string tag);
    logic [31:0] s, e, r;
    s = s0; e = e0;
    if (op == 0) begin
      if ((s & 32'h1F) != 0) begin
        push(0, s & ~32'h1F, s & ~32'h1F, tag);
        s = (s | 32'h1F) + 1;
      end
      if (s < e && (e & 32'h1F) != 0) begin
        push(0, e & ~32'h1F, e & ~32'h1F, tag);
        e = e & ~32'h1F;
      end
      while (s < e) begin
        r = chunk_of(s, e);
        push(2, s, r - 32, tag);
        s = r;
      end
    end else if (op == 1 || op == 2) begin
      s = s & ~32'h1F;
      e = (e + 32'h1F) & ~32'h1F;
      while (s < e) begin
        r = chunk_of(s, e);
        if (!wt) push(1, s, r - 32, tag);
        if (op == 2) push(2, s, r - 32, tag);
        s = r;
      end
    end
    push(3, 0, 0, tag);
  endtask

  task automatic submit(input int op, input logic [31:0] s, input logic [31:0] e,
                        input bit wt, input string tag);
    expect_req(op, s, e, wt, tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_start = s; req_end = e; wt_mode = wt;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    // R10: busy after acceptance
    check(req_ready == 1'b0, "R10", "req_ready after accept", {31'd0, req_ready}, 32'd0);
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_q.size() != 0 || !req_ready) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, "R8", "pending expected items", exp_q.size(), 0);
  endtask

  // ready pattern
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    cmd_ready = !stall_en || ((rdy_cnt % 3) != 0 && (rdy_cnt % 7) != 2);
  end

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [1:0]  h_kind;
  logic [31:0] h_lo, h_hi;

  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        // R9: stalled command unchanged
        check(cmd_valid && cmd_kind == h_kind && cmd_lo == h_lo && cmd_hi == h_hi,
              "R9", "held command lo", cmd_lo, h_lo);
      end
      held = cmd_valid && !cmd_ready;
      h_kind = cmd_kind; h_lo = cmd_lo; h_hi = cmd_hi;
      if (cmd_valid && done)
        check(1'b0, "R8", "done with cmd_valid", 1, 0);
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected command lo", cmd_lo, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(cmd_kind == x.kind[1:0] && x.kind != 3, x.tag, "cmd_kind", {30'd0, cmd_kind}, x.kind);
          check(cmd_lo == x.lo, x.tag, "cmd_lo", cmd_lo, x.lo);
          check(cmd_hi == x.hi, x.tag, "cmd_hi", cmd_hi, x.hi);
        end
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 1, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(x.kind == 3, x.tag, "done before commands (R8) kind", 3, x.kind);
        end
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_start = '0; req_end = '0;
    wt_mode = 1'b0; cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R13: reset state
    check(req_ready == 1'b1, "R13", "req_ready in reset", {31'd0, req_ready}, 1);
    check(cmd_valid == 1'b0, "R13", "cmd_valid in reset", {31'd0, cmd_valid}, 0);
    check(done == 1'b0, "R13", "done in reset", {31'd0, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && !cmd_valid && !done, "R13", "idle after reset",
          {31'd0, req_ready}, 1);

    submit(0, 32'h1000, 32'h1100, 0, "R1"); drain();
    submit(0, 32'h2005, 32'h2047, 0, "R3"); drain();
    submit(0, 32'h3004, 32'h300C, 0, "R4"); drain();
    submit(1, 32'h4000, 32'h4C00, 0, "R2"); drain();
    submit(1, 32'h5F00, 32'h6100, 0, "R2"); drain();
    submit(1, 32'h7011, 32'h7041, 0, "R5"); drain();
    stall_en = 1'b1;
    submit(2, 32'h8E00, 32'h9300, 0, "R6"); drain();
    submit(1, 32'h9000, 32'h9800, 1, "R7"); drain();
    submit(2, 32'hB3F0, 32'hB830, 1, "R7"); drain();
    submit(3, 32'hC000, 32'hD000, 0, "R11"); drain();
    submit(1, 32'hA000, 32'hA000, 0, "R12"); drain();
    submit(0, 32'hE010, 32'hE01F, 0, "R12"); drain();
    // R10: second request held while the first is busy
    submit(0, 32'hF7E3, 32'h10C41, 0, "R10");
    submit(3, 32'h0, 32'h40, 0, "R10");
    submit(2, 32'h20000, 32'h20840, 0, "R10");
    drain();
    stall_en = 1'b0;
    repeat (5) @(negedge clk);
    check(!cmd_valid && !done && req_ready, "R8", "quiet at end", {31'd0, cmd_valid}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule